// File: doc/BRIEF.md
# Time-Multiplexed Interrupt Level Requester

This block gathers the interrupt pending flags of a group of up to sixteen peripheral submodules, masks them with a per-source enable vector, and presents the resulting single request on a shared interrupt bus. The bus carries eight active-low request lines. A 2-bit slot counter supplied from outside cycles through four time slots. One line, asserted in one slot, therefore names one of 32 interrupt levels.

The whole group shares one programmed level. That level sits in a small register that is written and read through a plain register port. The block does not identify which source raised the request. Software reads the pending vector and searches it, for example with a find-first-one scan, to find the source.

Top module: `irq_slot_requester`

## Requirements
- R1: The internal request is active exactly when `pend_i & en_i` has at least one bit set. Pending bits whose enable bit is 0 have no effect on any output.
- R2: The level field occupies register bits [4:0]. Bits [4:2] hold the line number (0..7) and bits [1:0] hold the slot number (0..3). For example, code 5'b100_01 selects line 4 in slot 1.
- R3: While the request is active and `slot_i` equals the programmed slot, `irq_n_o[line]` is 0 and the other seven lines are 1.
- R4: In any cycle where `slot_i` differs from the programmed slot, all eight lines are 1.
- R5: While the request is inactive, all eight lines are 1.
- R6: While `rst_n` is low at a clock edge, the level register is cleared to 0.
- R7: A register write with `reg_we` high takes effect at the next rising clock edge and not before. A request that is already active moves to the new line and slot without being dropped.
- R8: `reg_rdata[4:0]` returns the stored level and `reg_rdata[15:5]` reads 0. Write data in bits [15:5] is discarded.
- R9: `slot_hit_o` is 1 exactly when `slot_i` equals the programmed slot, whether or not a request is active.
- R10: Each of the 16 sources, taken alone with its enable set, raises the same programmed line and slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_i | input | 16 | Pending flags, one per source |
| en_i | input | 16 | Enable mask, one per source |
| reg_we | input | 1 | Level register write strobe |
| reg_wdata | input | 16 | Level register write data |
| reg_rdata | output | 16 | Level register read data |
| slot_i | input | 2 | Current bus time slot |
| irq_n_o | output | 8 | Active-low request lines |
| slot_hit_o | output | 1 | Current slot equals the programmed slot |

## Verification
The register write and the live request can happen in the same cycle. When a new level is written while an enabled flag is pending, the old line must stay asserted up to the clock edge and the new line must take over right after it. The bench holds an active request with `slot_i` set to the new slot. It then writes a different code and samples the lines just before and just after the capturing edge. Each sample is compared with the pattern computed from the old code and from the new code.

// File: rtl/irq_lvl_pkg.sv
// Package: shared constants and the level encoding for the slot requester.
// Assumes a fixed bus of eight request lines and four time slots.
package irq_lvl_pkg;

    localparam int NUM_LINES = 8;
    localparam int NUM_SLOTS = 4;
    localparam int LINE_W    = $clog2(NUM_LINES);
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int LVL_W     = LINE_W + SLOT_W;

    // Level code: line number in the upper bits, slot number in the lower bits.
    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic [SLOT_W-1:0] slot;
    } level_t;

endpackage

// File: rtl/irq_lvl_reg.sv
// Module: holds the programmed interrupt level and provides read-back.
// Assumes REG_W > LVL_W. Bits above the level field are dropped on write
// and read as zero.
module irq_lvl_reg
    import irq_lvl_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output level_t           level_o,
    output logic [REG_W-1:0] rdata
);

    level_t level_q;

    // Capture a new level on a write; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
        end else if (we) begin
            level_q <= level_t'(wdata[LVL_W-1:0]);
        end
    end

    // Zero-extend the stored level onto the read bus.
    always_comb begin
        rdata              = '0;
        rdata[LVL_W-1:0]   = level_q;
    end

    assign level_o = level_q;

endmodule

// File: rtl/irq_req_collect.sv
// Module: masks pending flags with their enables and ORs them into one request.
// Assumes both vectors are already synchronous to clk.
module irq_req_collect #(
    parameter int N_SRC = 16
) (
    input  logic [N_SRC-1:0] pend,
    input  logic [N_SRC-1:0] en,
    output logic             req
);

    logic [N_SRC-1:0] masked;

    // One masking gate per source.
    for (genvar s = 0; s < N_SRC; s++) begin : g_mask
        assign masked[s] = pend[s] & en[s];
    end

    // Any enabled pending source raises the group request.
    always_comb begin
        req = |masked;
    end

endmodule

// File: rtl/irq_line_drive.sv
// Module: decodes the level into one active-low line, gated by slot match.
// Assumes slot_i is the bus slot counter for the current cycle.
module irq_line_drive
    import irq_lvl_pkg::*;
(
    input  logic                 req,
    input  level_t               level,
    input  logic [SLOT_W-1:0]    slot_i,
    output logic [NUM_LINES-1:0] irq_n,
    output logic                 slot_hit
);

    // Slot comparator shared by every line.
    always_comb begin
        slot_hit = (slot_i == level.slot);
    end

    // One decoder per line: pull low only when selected, requested and in slot.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        assign irq_n[g] = ~(req && slot_hit && (level.line == LINE_W'(g)));
    end

endmodule

// File: rtl/irq_slot_requester.sv
// Module (top): time-multiplexed interrupt level requester for a group of
// sources that share one programmed level. The outputs are combinational
// from the inputs and the level register, so the block adds no latency.
module irq_slot_requester
    import irq_lvl_pkg::*;
#(
    parameter int N_SRC = 16,
    parameter int REG_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_SRC-1:0]     pend_i,
    input  logic [N_SRC-1:0]     en_i,
    input  logic                 reg_we,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic [SLOT_W-1:0]    slot_i,
    output logic [NUM_LINES-1:0] irq_n_o,
    output logic                 slot_hit_o
);

    level_t level;
    logic   req;

    irq_lvl_reg #(.REG_W(REG_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .wdata   (reg_wdata),
        .level_o (level),
        .rdata   (reg_rdata)
    );

    irq_req_collect #(.N_SRC(N_SRC)) u_collect (
        .pend (pend_i),
        .en   (en_i),
        .req  (req)
    );

    irq_line_drive u_drive (
        .req      (req),
        .level    (level),
        .slot_i   (slot_i),
        .irq_n    (irq_n_o),
        .slot_hit (slot_hit_o)
    );

endmodule

// File: rtl/irq_slot_requester_chk.sv
// Checker: port-level properties of irq_slot_requester, attached by bind.
module irq_slot_requester_chk
    import irq_lvl_pkg::*;
#(
    parameter int N_SRC = 16,
    parameter int REG_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_SRC-1:0]     pend_i,
    input logic [N_SRC-1:0]     en_i,
    input logic                 reg_we,
    input logic [REG_W-1:0]     reg_wdata,
    input logic [REG_W-1:0]     reg_rdata,
    input logic [SLOT_W-1:0]    slot_i,
    input logic [NUM_LINES-1:0] irq_n_o,
    input logic                 slot_hit_o
);

    // R1, R5: no enabled pending flag means every line is released.
    a_r5_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_i & en_i) == '0) |-> (&irq_n_o));

    // R3: at most one line is asserted at any time.
    a_r3_single_line: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~irq_n_o) <= 1);

    // R3: an active request in the matching slot asserts the programmed line.
    a_r3_line_select: assert property (@(posedge clk) disable iff (!rst_n)
        (((pend_i & en_i) != '0) && slot_hit_o) |-> !irq_n_o[reg_rdata[LVL_W-1:SLOT_W]]);

    // R4: outside the programmed slot every line is released.
    a_r4_off_slot: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_hit_o |-> (&irq_n_o));

    // R9: the slot-match output follows the slot input and the stored slot.
    a_r9_slot_hit: assert property (@(posedge clk) disable iff (!rst_n)
        slot_hit_o == (slot_i == reg_rdata[SLOT_W-1:0]));

    // R6: reset clears the stored level.
    a_r6_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (reg_rdata == '0));

    // R7, R8: a write becomes visible on the next cycle, masked to the level field.
    a_r7_write_next: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (reg_rdata[LVL_W-1:0] == $past(reg_wdata[LVL_W-1:0])));

    // R8: read-back bits above the level field stay zero.
    a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[REG_W-1:LVL_W] == '0);

endmodule

bind irq_slot_requester irq_slot_requester_chk #(.N_SRC(N_SRC), .REG_W(REG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_i     (pend_i),
    .en_i       (en_i),
    .reg_we     (reg_we),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .slot_i     (slot_i),
    .irq_n_o    (irq_n_o),
    .slot_hit_o (slot_hit_o)
);

// File: tb/test_irq_slot_requester.sv
// Bench: sweeps all 32 level codes across every slot with random masks.
// Inputs are driven at the falling edge and outputs sampled 2 ns later.
module test_irq_slot_requester;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] pend_i, en_i, reg_wdata, reg_rdata;
    logic        reg_we;
    logic [1:0]  slot_i;
    logic [7:0]  irq_n_o;
    logic        slot_hit_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    irq_slot_requester i_irq_slot_requester (
        .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .en_i(en_i),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .slot_i(slot_i), .irq_n_o(irq_n_o), .slot_hit_o(slot_hit_o)
    );

    // Expected line pattern computed from the requirements.
    function automatic logic [7:0] exp_irq(input logic [15:0] p, input logic [15:0] e,
                                           input logic [4:0] code, input logic [1:0] s);
        logic [7:0] v;
        v = 8'hFF;
        if (((p & e) != 16'h0) && (s == code[1:0])) v[code[4:2]] = 1'b0;
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_lvl(input logic [15:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pend_i = '0; en_i = '0; reg_we = 1'b0; reg_wdata = '0; slot_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #2;
        chk("R6 reset level", 32'(reg_rdata), 32'h0);
        chk("R5 reset lines", 32'(irq_n_o), 32'hFF);
        rst_n = 1'b1;

        // R2: field positions, code 100_01 selects line 4 in slot 1.
        write_lvl(16'h0011);
        pend_i = 16'h0100; en_i = 16'h0100; slot_i = 2'd1;
        #2;
        chk("R2 line4 slot1", 32'(irq_n_o), 32'hEF);

        // Full sweep of the level codes.
        for (int code = 0; code < 32; code++) begin
            logic [15:0] wd;
            wd = {11'(16'($urandom()) >> 5), 5'(code)};
            write_lvl(wd);
            #2;
            chk("R8 readback masked", 32'(reg_rdata), 32'(code));
            for (int s = 0; s < 4; s++) begin
                for (int pat = 0; pat < 3; pat++) begin
                    logic [15:0] p, e;
                    p = 16'($urandom());
                    e = 16'($urandom());
                    if (pat == 0) begin
                        p = 16'h1 << (code % 16);
                        e = 16'h1 << (code % 16);
                    end else if (pat == 1) begin
                        e = ~p;
                    end
                    @(negedge clk);
                    pend_i = p; en_i = e; slot_i = 2'(s);
                    #2;
                    if (pat == 0)
                        chk("R10 single source", 32'(irq_n_o), 32'(exp_irq(p, e, 5'(code), 2'(s))));
                    else if (pat == 1)
                        chk("R1 disabled ignored", 32'(irq_n_o), 32'hFF);
                    else if ((p & e) == 16'h0)
                        chk("R5 no request", 32'(irq_n_o), 32'hFF);
                    else if (2'(s) != 2'(code))
                        chk("R4 off slot", 32'(irq_n_o), 32'hFF);
                    else
                        chk("R3 line select", 32'(irq_n_o), 32'(exp_irq(p, e, 5'(code), 2'(s))));
                    chk("R9 slot hit", 32'(slot_hit_o), 32'(2'(s) == 2'(code)));
                end
            end
        end

        // R7: move an active request from code 00011 to 11010.
        write_lvl(16'h0003);
        pend_i = 16'h8000; en_i = 16'hFFFF; slot_i = 2'd2;
        @(negedge clk);
        reg_we = 1'b1; reg_wdata = 16'h001A;
        #2;
        chk("R7 old level before edge", 32'(irq_n_o), 32'hFF);
        slot_i = 2'd3;
        #2;
        chk("R7 old line before edge", 32'(irq_n_o), 32'hFE);
        slot_i = 2'd2;
        @(negedge clk);
        reg_we = 1'b0;
        #2;
        chk("R7 new line after edge", 32'(irq_n_o), 32'hBF);

        // R6: reset in the middle of operation clears the level.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk("R6 mid-run reset", 32'(reg_rdata), 32'h0);
        slot_i = 2'd0;
        #2;
        chk("R6 level 0 line", 32'(irq_n_o), 32'hFE);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule